// File: doc/BRIEF.md
# NAND read prefetch engine

This block fetches a programmed number of bytes from a byte-wide NAND data port and stages them in an on-chip FIFO. A host drains the FIFO one 32-bit word at a time. Software programs a byte count and a configuration word, then sets the run bit. While the engine runs, it issues one read strobe per clock toward the flash device. It stalls whenever the FIFO is full and stops once every programmed byte has been fetched.

The host polls a status word that holds the bytes still to fetch and the FIFO byte occupancy. It pops one word for every four bytes of occupancy. When the transfer is complete, the engine drops its busy indication by itself. Software then tidies up by writing zero to the control register and then to the configuration register. The block handles whole words only. Any byte residue is left to the caller.

Top module: `nand_pf_engine`

## Requirements
- R1: After a synchronous reset, all four registers read 0 and no read strobe is issued.
- R2: The configuration register (address 0) keeps the direction in bit 0, the enable flag in bit 7, the FIFO threshold in bits 14:8 and the chip-select number in bits 26:24. All other bits read back as 0.
- R3: A configuration write whose threshold field is greater than 64 is rejected and leaves the register unchanged. A threshold of exactly 64 is accepted.
- R4: The byte-count register (address 1) keeps bits 13:0 of the written value.
- R5: Writing a value with bit 0 set to the control register (address 2) starts the engine only when the enable flag is set and the engine is idle. A start loads the remaining count from the byte-count register and empties the FIFO. The control register reads 1 while the engine is busy.
- R6: A start request made while the engine is busy is refused. The remaining count is not reloaded, and the FIFO is not touched.
- R7: A read strobe is issued only while the engine is busy, the remaining count is nonzero and the FIFO holds fewer than 64 bytes. Each strobe captures one byte and lowers the remaining count by one.
- R8: One cycle after the remaining count reaches 0 on a busy engine, busy clears without any software action.
- R9: The status register (address 3) returns the remaining count in bits 13:0 and the FIFO byte occupancy in bits 30:24.
- R10: A host pop while the FIFO holds at least 4 bytes returns the oldest word, on the next cycle, with the first fetched byte in bits 7:0, and lowers the occupancy by 4. A pop with fewer than 4 bytes is ignored, and the output word holds its value.
- R11: Writing a value with bit 0 clear to the control register aborts the engine. Busy clears, the remaining count goes to 0 and the FIFO empties.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe; data appears on the next cycle |
| reg_addr | input | 2 | Register select: 0 config, 1 byte count, 2 control, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| nd_rd_strobe | output | 1 | Read strobe toward the flash data port |
| nd_rdata | input | 8 | Flash data byte, captured on an edge where the strobe is high |
| host_pop | input | 1 | Host request for one FIFO word |
| host_data | output | 32 | Registered word returned by a pop |

## Verification
On every cycle, the bound checker enforces the conditions under which a strobe may be issued: busy, count nonzero and room in the FIFO. It also checks the one-step decrement of the remaining count, the occupancy ceiling and the four-byte drop on a pop, as well as the self-clearing of busy once the count is spent. Other behaviours can only be shown by the bench's scenarios: byte order inside each drained word, rejection of an oversized threshold, refusal of a second start, the enable gate and the abort path. The bench exercises each of these through register readback and popped data, including a transfer longer than the FIFO that forces back-pressure.

// File: rtl/nand_pf_pkg.sv
package nand_pf_pkg;
  typedef enum logic [1:0] {
    PF_CFG1 = 2'd0,
    PF_CFG2 = 2'd1,
    PF_CTRL = 2'd2,
    PF_STAT = 2'd3
  } pf_reg_e;

  localparam int DIR_BIT      = 0;
  localparam int EN_BIT       = 7;
  localparam int THR_LSB      = 8;
  localparam int THR_W        = 7;
  localparam int CS_LSB       = 24;
  localparam int STAT_OCC_LSB = 24;
endpackage

// File: rtl/nand_pf_regs.sv
module nand_pf_regs
  import nand_pf_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int CS_W    = 3,
  parameter int THR_MAX = 64,
  parameter int OCC_W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] rem,
  input  logic [OCC_W-1:0] occ,
  input  logic             fetch_done,
  output logic [31:0]      rdata,
  output logic             busy,
  output logic             start,
  output logic             abort,
  output logic [CNT_W-1:0] load_count
);
  logic             dir_q, en_q;
  logic [THR_W-1:0] thr_q;
  logic [CS_W-1:0]  cs_q;
  logic [31:0]      rd_n;
  logic             ctrl_wr, cfg1_ok;

  assign ctrl_wr = wr_en && (addr == PF_CTRL);
  assign start   = ctrl_wr && wdata[0] && !busy && en_q;
  assign abort   = ctrl_wr && !wdata[0];
  assign cfg1_ok = wdata[THR_LSB +: THR_W] <= THR_W'(THR_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q      <= 1'b0;
      en_q       <= 1'b0;
      thr_q      <= '0;
      cs_q       <= '0;
      load_count <= '0;
      busy       <= 1'b0;
    end else begin
      if (wr_en && addr == PF_CFG1 && cfg1_ok) begin
        dir_q <= wdata[DIR_BIT];
        en_q  <= wdata[EN_BIT];
        thr_q <= wdata[THR_LSB +: THR_W];
        cs_q  <= wdata[CS_LSB +: CS_W];
      end
      if (wr_en && addr == PF_CFG2)
        load_count <= wdata[CNT_W-1:0];
      if (start)
        busy <= 1'b1;
      else if (abort || fetch_done)
        busy <= 1'b0;
    end
  end

  always_comb begin
    rd_n = '0;
    unique case (addr)
      PF_CFG1: begin
        rd_n[DIR_BIT]             = dir_q;
        rd_n[EN_BIT]              = en_q;
        rd_n[THR_LSB +: THR_W]    = thr_q;
        rd_n[CS_LSB +: CS_W]      = cs_q;
      end
      PF_CFG2: rd_n[CNT_W-1:0] = load_count;
      PF_CTRL: rd_n[0] = busy;
      PF_STAT: begin
        rd_n[CNT_W-1:0]               = rem;
        rd_n[STAT_OCC_LSB +: OCC_W]   = occ;
      end
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_n;
  end
endmodule

// File: rtl/nand_pf_fetch.sv
module nand_pf_fetch #(
  parameter int CNT_W      = 14,
  parameter int FIFO_BYTES = 64,
  parameter int OCC_W      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             start,
  input  logic             abort,
  input  logic [CNT_W-1:0] load_count,
  input  logic [OCC_W-1:0] occ,
  output logic             strobe,
  output logic [CNT_W-1:0] rem,
  output logic             done
);
  assign strobe = busy && (rem != '0) && (occ < OCC_W'(FIFO_BYTES));
  assign done   = busy && (rem == '0);

  always_ff @(posedge clk) begin
    if (rst || abort) rem <= '0;
    else if (start)   rem <= load_count;
    else if (strobe)  rem <= rem - CNT_W'(1);
  end
endmodule

// File: rtl/nand_pf_fifo.sv
module nand_pf_fifo #(
  parameter int FIFO_BYTES = 64,
  parameter int OCC_W      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [7:0]       push_byte,
  input  logic             pop,
  output logic [31:0]      pop_data,
  output logic [OCC_W-1:0] occ
);
  localparam int WORDS = FIFO_BYTES / 4;
  localparam int PTR_W = $clog2(WORDS);

  logic [31:0]      mem [WORDS];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [1:0]       lane;
  logic [23:0]      pack;
  logic             pop_ok, word_wr;

  assign pop_ok  = pop && (occ >= OCC_W'(4)) && !flush;
  assign word_wr = push && !flush && (lane == 2'd3);

  always_ff @(posedge clk) begin
    if (word_wr) mem[wr_ptr] <= {push_byte, pack};
  end

  always_ff @(posedge clk) begin
    if (rst)         pop_data <= '0;
    else if (pop_ok) pop_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      lane   <= '0;
      pack   <= '0;
      occ    <= '0;
    end else begin
      if (push) begin
        lane <= lane + 2'd1;
        if (lane != 2'd3) pack[lane*8 +: 8] <= push_byte;
        else              wr_ptr <= wr_ptr + PTR_W'(1);
      end
      if (pop_ok) rd_ptr <= rd_ptr + PTR_W'(1);
      occ <= occ + OCC_W'(push) - (pop_ok ? OCC_W'(4) : OCC_W'(0));
    end
  end
endmodule

// File: rtl/nand_pf_engine.sv
module nand_pf_engine #(
  parameter int CNT_W      = 14,
  parameter int CS_W       = 3,
  parameter int THR_MAX    = 64,
  parameter int FIFO_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        nd_rd_strobe,
  input  logic [7:0]  nd_rdata,
  input  logic        host_pop,
  output logic [31:0] host_data
);
  localparam int OCC_W = $clog2(FIFO_BYTES + 1);

  logic             busy, start, abort, done;
  logic [CNT_W-1:0] rem, load_count;
  logic [OCC_W-1:0] occ;

  nand_pf_regs #(.CNT_W(CNT_W), .CS_W(CS_W), .THR_MAX(THR_MAX), .OCC_W(OCC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
    .wdata(reg_wdata), .rem(rem), .occ(occ), .fetch_done(done), .rdata(reg_rdata),
    .busy(busy), .start(start), .abort(abort), .load_count(load_count)
  );

  nand_pf_fetch #(.CNT_W(CNT_W), .FIFO_BYTES(FIFO_BYTES), .OCC_W(OCC_W)) u_fetch (
    .clk(clk), .rst(rst), .busy(busy), .start(start), .abort(abort),
    .load_count(load_count), .occ(occ), .strobe(nd_rd_strobe), .rem(rem), .done(done)
  );

  nand_pf_fifo #(.FIFO_BYTES(FIFO_BYTES), .OCC_W(OCC_W)) u_fifo (
    .clk(clk), .rst(rst), .flush(start || abort), .push(nd_rd_strobe),
    .push_byte(nd_rdata), .pop(host_pop), .pop_data(host_data), .occ(occ)
  );
endmodule

// File: rtl/nand_pf_engine_chk.sv
module nand_pf_engine_chk #(
  parameter int CNT_W      = 14,
  parameter int FIFO_BYTES = 64,
  parameter int OCC_W      = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             strobe,
  input logic             busy,
  input logic [CNT_W-1:0] rem,
  input logic [OCC_W-1:0] occ,
  input logic             ctrl_wr,
  input logic             host_pop
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && occ == '0 && rem == '0 && !strobe));

  // R7
  a_r7_strobe_gated: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (busy && rem != '0 && occ < OCC_W'(FIFO_BYTES)));

  // R7
  a_r7_rem_step: assert property (@(posedge clk) disable iff (rst)
    (strobe && !ctrl_wr) |=> (rem == $past(rem) - CNT_W'(1)));

  // R8
  a_r8_auto_idle: assert property (@(posedge clk) disable iff (rst)
    (busy && rem == '0) |=> !busy);

  // R10
  a_r10_occ_cap: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(FIFO_BYTES));

  // R10
  a_r10_pop_step: assert property (@(posedge clk) disable iff (rst)
    (host_pop && occ >= OCC_W'(4) && !strobe && !ctrl_wr) |=> (occ == $past(occ) - OCC_W'(4)));
endmodule

bind nand_pf_engine nand_pf_engine_chk #(
  .CNT_W(CNT_W), .FIFO_BYTES(FIFO_BYTES), .OCC_W(OCC_W)
) u_chk (
  .clk(clk), .rst(rst), .strobe(nd_rd_strobe), .busy(busy), .rem(rem), .occ(occ),
  .ctrl_wr(reg_wr_en && reg_addr == 2'd2), .host_pop(host_pop)
);

// File: tb/nand_pf_engine_tb.sv
module nand_pf_engine_tb;
  localparam time CYC = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nd_rd_strobe;
  logic [7:0]  nd_rdata;
  logic        host_pop = 1'b0;
  logic [31:0] host_data;
  logic [15:0] dev_idx;

  int checks = 0;
  int fails  = 0;

  always #(CYC/2) clk = ~clk;

  nand_pf_engine u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nd_rd_strobe(nd_rd_strobe), .nd_rdata(nd_rdata),
    .host_pop(host_pop), .host_data(host_data)
  );

  // Flash device model: byte value is a function of its running index.
  function automatic logic [7:0] devb(input logic [15:0] i);
    return i[7:0] * 8'd37 + 8'd11;
  endfunction

  always @(posedge clk) begin
    if (rst) dev_idx <= '0;
    else if (nd_rd_strobe) dev_idx <= dev_idx + 16'd1;
  end
  assign nd_rdata = devb(dev_idx);

  // {threshold, byte count}
  localparam logic [23:0] VEC [4] = '{
    {8'h40, 16'd8}, {8'h20, 16'd64}, {8'h08, 16'd100}, {8'h40, 16'd4}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pop1(output logic [31:0] d);
    @(negedge clk);
    host_pop = 1'b1;
    @(negedge clk);
    host_pop = 1'b0;
    d = host_data;
  endtask

  initial begin
    #(CYC * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, w, hold;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 32'h0, "R1 register after reset", v, 32'h0);
    end
    chk(nd_rd_strobe == 1'b0, "R1 strobe after reset", {31'b0, nd_rd_strobe}, 32'h0);

    // R2: field layout, unused bits read 0
    wr(2'd0, 32'hF0F0_20FF);
    rd(2'd0, v);
    chk(v == 32'h0000_2081, "R2 cfg field layout", v, 32'h0000_2081);
    wr(2'd0, 32'h0300_1080);
    rd(2'd0, v);
    chk(v == 32'h0300_1080, "R2 chip select field", v, 32'h0300_1080);

    // R3: threshold 64 accepted, 65 rejected
    wr(2'd0, 32'h0000_4080);
    rd(2'd0, v);
    chk(v == 32'h0000_4080, "R3 threshold 64 accepted", v, 32'h0000_4080);
    wr(2'd0, 32'h0000_4181);
    rd(2'd0, v);
    chk(v == 32'h0000_4080, "R3 threshold 65 rejected", v, 32'h0000_4080);

    // R4: count width
    wr(2'd1, 32'hFFFF_C123);
    rd(2'd1, v);
    chk(v == 32'h0000_0123, "R4 count field", v, 32'h0000_0123);

    // R5: start ignored without enable
    wr(2'd0, 32'h0000_4000);
    wr(2'd1, 32'd8);
    wr(2'd2, 32'd1);
    rd(2'd2, v);
    chk(v == 32'h0, "R5 start needs enable", v, 32'h0);
    chk(nd_rd_strobe == 1'b0, "R5 no strobe when not enabled", {31'b0, nd_rd_strobe}, 32'h0);

    // R7/R9/R5/R6: long transfer stalls on a full FIFO, restart refused
    wr(2'd0, 32'h0000_4080);
    wr(2'd1, 32'd72);
    wr(2'd2, 32'd1);
    repeat (80) @(negedge clk);
    chk(nd_rd_strobe == 1'b0, "R7 stalls when FIFO full", {31'b0, nd_rd_strobe}, 32'h0);
    rd(2'd3, v);
    chk(v == 32'h4000_0008, "R9 status full FIFO", v, 32'h4000_0008);
    rd(2'd2, v);
    chk(v == 32'h1, "R5 busy reads 1", v, 32'h1);
    wr(2'd1, 32'd4);
    wr(2'd2, 32'd1);
    rd(2'd3, v);
    chk(v == 32'h4000_0008, "R6 restart refused", v, 32'h4000_0008);

    // R11: abort, then clear config
    wr(2'd2, 32'd0);
    rd(2'd2, v);
    chk(v == 32'h0, "R11 abort clears busy", v, 32'h0);
    rd(2'd3, v);
    chk(v == 32'h0, "R11 abort empties FIFO and count", v, 32'h0);
    wr(2'd0, 32'd0);
    rd(2'd0, v);
    chk(v == 32'h0, "R11 config cleared", v, 32'h0);

    // R10: pop on empty FIFO is ignored
    hold = host_data;
    pop1(w);
    chk(w == hold, "R10 empty pop holds data", w, hold);
    rd(2'd3, v);
    chk(v == 32'h0, "R10 empty pop leaves occupancy", v, 32'h0);

    // R8: zero-byte start returns to idle
    wr(2'd0, 32'h0000_4080);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd1);
    rd(2'd2, v);
    chk(v == 32'h0, "R8 zero count self-clears", v, 32'h0);
    wr(2'd2, 32'd0);
    wr(2'd0, 32'd0);

    // Vector table: full transfers, drained word by word
    for (int t = 0; t < 4; t++) begin
      logic [15:0] base;
      int          nwords, popped;
      nwords = int'(VEC[t][15:0]) / 4;
      wr(2'd0, {16'h0, VEC[t][23:16], 8'h80});
      wr(2'd1, {16'h0, VEC[t][15:0]});
      base = dev_idx;
      wr(2'd2, 32'd1);
      popped = 0;
      while (popped < nwords) begin
        rd(2'd3, v);
        if (v[30:24] >= 7'd4) begin
          logic [31:0] exp;
          for (int j = 0; j < 4; j++)
            exp[j*8 +: 8] = devb(base + 16'(popped * 4 + j));
          pop1(w);
          chk(w == exp, "R10 popped word little-endian", w, exp);
          popped++;
        end
      end
      repeat (3) @(negedge clk);
      rd(2'd2, v);
      chk(v == 32'h0, "R8 idle after transfer", v, 32'h0);
      rd(2'd3, v);
      chk(v == 32'h0, "R9 status drained", v, 32'h0);
      wr(2'd2, 32'd0);
      wr(2'd0, 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule